// File: doc/BRIEF.md
# OTP Programming Pulse Sequencer

This block sits on the programmer side of a one-time-programmable code store. It writes one byte at a time into the code array, the encryption table or a lock bit. A command carries a target kind, a 15-bit address and a data byte. Once the block accepts a command, it runs the whole programming sequence on its own: it drives the address and data lines and the mode-select pattern, requests the high programming voltage, and fires a burst of active-low PROG pulses whose count depends on the target. It then releases the voltage and keeps the address steady through the hold window.

For code bytes, the sequence ends with a verify read. The block switches the mode lines to verify, releases the data bus and pulls the verify enable low. At the end of the data-valid window it compares the returned byte with the byte it wrote. All timing comes from two sources. Microsecond windows are built from a clocks-per-microsecond parameter. Address and data windows are built from a per-command count of clock cycles per target-oscillator period, sampled when the command is accepted.

Top module: `otp_prog_seq`

## Requirements
- R1: The block accepts a command in a cycle where `cmd_valid` is high, `busy` is low and `cmd_kind` is not 2'b11. The kind encoding is 2'b00 code byte, 2'b01 encryption byte, 2'b10 lock bit. `busy` is high from the next cycle until the sequence finishes. A command with kind 2'b11 is ignored: `busy` stays low, and PROG, the voltage request and the verify enable do not move.
- R2: While `busy` is high, a new command has no effect. `pin_addr` and `pin_data` keep the values of the accepted command, and the pulse count is unchanged.
- R3: PROG falls exactly CODE_PULSES (5) times for a code byte, and exactly AUX_PULSES (25) times for an encryption byte or a lock bit.
- R4: Each PROG low pulse lasts PULSE_US×CYC_PER_US cycles. Each high gap between two pulses lasts GAP_US×CYC_PER_US cycles.
- R5: Let H be HOLD_OSC (48) times the latched oscillator count. The address, the data (with `data_oe` high) and the mode pattern are driven H + VPP_SETUP_US×CYC_PER_US cycles before the first PROG fall. They stay driven for VPP_HOLD_US×CYC_PER_US + H cycles after the last PROG rise.
- R6: `vpp_req` rises VPP_SETUP_US×CYC_PER_US cycles before the first PROG fall. It falls VPP_HOLD_US×CYC_PER_US cycles after the last PROG rise. PROG is never low without `vpp_req`.
- R7: A code byte is followed by a verify phase that starts after the address hold. In this phase `mode_sel` is 3'b011, `data_oe` and `vpp_req` are low, and `vfy_en_n` is low for H cycles. `vfy_data` is sampled in the last of those cycles. `err` is set when the sampled value differs from the written byte.
- R8: Encryption and lock commands have no verify phase. `vfy_en_n` stays high and `err` stays low for them.
- R9: `done` is high for exactly one cycle at the end of each accepted command. `busy` is low in the following cycle. `err` is only ever high together with `done`.
- R10: An oscillator count of zero is treated as one, so H is 48 cycles.
- R11: While the programming pulses run, `mode_sel` is 3'b001 for code, 3'b010 for encryption and 3'b100 for lock. It is 3'b000 whenever the block is idle.
- R12: After reset, `busy`, `vpp_req`, `data_oe`, `done` and `err` are low, `prog_n` and `vfy_en_n` are high, `mode_sel` is 3'b000 and `pin_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_kind | input | 2 | Target kind: code, encryption, lock, reserved |
| cmd_addr | input | AW | Target address |
| cmd_data | input | DW | Byte to program |
| osc_cycles | input | OSC_W | Clock cycles per target-oscillator period |
| busy | output | 1 | Sequence in progress; commands ignored |
| pin_addr | output | AW | Address lines to the target |
| pin_data | output | DW | Data lines to the target |
| data_oe | output | 1 | Data lines driven by the sequencer |
| mode_sel | output | 3 | Mode-select pattern |
| vpp_req | output | 1 | Request for the high programming voltage |
| prog_n | output | 1 | Active-low programming strobe |
| vfy_en_n | output | 1 | Active-low verify enable |
| vfy_data | input | DW | Readback byte from the target |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Verify mismatch, valid with `done` |

## Verification
The assertions assume that the external voltage and timing parameters are at least one, so every phase lasts at least a cycle. They also assume that `vfy_data` is only meaningful while `vfy_en_n` is low. The bench stand-in drives readback only in that window. It changes `cmd_*` and `osc_cycles` only on falling clock edges. It offers commands during a busy sequence, and a reserved kind, only to show that the block ignores them. It never relies on a mid-sequence change of `osc_cycles`.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [1:0] {
    K_CODE = 2'b00,
    K_ENC  = 2'b01,
    K_LOCK = 2'b10,
    K_RSVD = 2'b11
  } tgt_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_VUP, S_PLOW, S_PGAP, S_VHOLD, S_AHOLD, S_VFY, S_FIN
  } seq_state_e;

  localparam logic [2:0] MODE_OFF  = 3'b000;
  localparam logic [2:0] MODE_CODE = 3'b001;
  localparam logic [2:0] MODE_ENC  = 3'b010;
  localparam logic [2:0] MODE_LOCK = 3'b100;
  localparam logic [2:0] MODE_VFY  = 3'b011;

  // Address/data window in clock cycles: periods times oscillator count, zero clamped to one.
  function automatic int unsigned osc_window(int unsigned periods, int unsigned osc);
    return periods * ((osc == 0) ? 1 : osc);
  endfunction

  // Microsecond window in clock cycles.
  function automatic int unsigned us_window(int unsigned us, int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int unsigned pulses_for(tgt_kind_e k, int unsigned n_code, int unsigned n_aux);
    return (k == K_CODE) ? n_code : n_aux;
  endfunction

  function automatic logic [2:0] mode_for(tgt_kind_e k);
    case (k)
      K_CODE:  return MODE_CODE;
      K_ENC:   return MODE_ENC;
      K_LOCK:  return MODE_LOCK;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/otp_dwell_timer.sv
module otp_dwell_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // The timer never leaves zero unless it is reloaded (phase lengths cannot wrap).
  assert_timer_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == '0 && !$past(load)) |-> cnt == '0);
endmodule

// File: rtl/otp_pulse_ctr.sv
module otp_pulse_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] target,
  output logic          last
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign last = (count == target - 1'b1);

  // Never more pulses than the target asks for.
  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && target != '0) |-> count <= target);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int AW           = 15,
  parameter int DW           = 8,
  parameter int OSC_W        = 8,
  parameter int CYC_PER_US   = 20,
  parameter int PULSE_US     = 95,
  parameter int GAP_US       = 10,
  parameter int VPP_SETUP_US = 10,
  parameter int VPP_HOLD_US  = 10,
  parameter int HOLD_OSC     = 48,
  parameter int CODE_PULSES  = 5,
  parameter int AUX_PULSES   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  input  logic [OSC_W-1:0] osc_cycles,
  output logic             busy,
  output logic [AW-1:0]    pin_addr,
  output logic [DW-1:0]    pin_data,
  output logic             data_oe,
  output logic [2:0]       mode_sel,
  output logic             vpp_req,
  output logic             prog_n,
  output logic             vfy_en_n,
  input  logic [DW-1:0]    vfy_data,
  output logic             done,
  output logic             err
);
  localparam int MAXP = (AUX_PULSES > CODE_PULSES) ? AUX_PULSES : CODE_PULSES;
  localparam int CW   = $clog2(MAXP + 1);
  localparam int TW   = $clog2(HOLD_OSC * (2 ** OSC_W) + PULSE_US * CYC_PER_US
                               + GAP_US * CYC_PER_US + 1);
  localparam logic [TW-1:0] LEN_VUP  = TW'(us_window(VPP_SETUP_US, CYC_PER_US) - 1);
  localparam logic [TW-1:0] LEN_LOW  = TW'(us_window(PULSE_US, CYC_PER_US) - 1);
  localparam logic [TW-1:0] LEN_GAP  = TW'(us_window(GAP_US, CYC_PER_US) - 1);
  localparam logic [TW-1:0] LEN_VHLD = TW'(us_window(VPP_HOLD_US, CYC_PER_US) - 1);

  seq_state_e     st, st_nxt;
  tgt_kind_e      r_kind;
  logic [AW-1:0]  r_addr;
  logic [DW-1:0]  r_data;
  logic [TW-1:0]  r_hold;     // H - 1, latched at acceptance
  logic           r_mism;

  // Named internal events
  logic           accept;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_zero;
  logic           pulse_end;
  logic           pulse_last;
  logic           vfy_sample;
  logic [CW-1:0]  pulse_tgt;

  assign accept     = (st == S_IDLE) && cmd_valid && (tgt_kind_e'(cmd_kind) != K_RSVD);
  assign pulse_end  = (st == S_PLOW) && tmr_zero;
  assign vfy_sample = (st == S_VFY) && tmr_zero;
  assign pulse_tgt  = CW'(pulses_for(r_kind, CODE_PULSES, AUX_PULSES));

  otp_dwell_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  otp_pulse_ctr #(.CW(CW)) u_pc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(pulse_end),
    .target(pulse_tgt), .last(pulse_last)
  );

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      S_IDLE: if (accept) begin
        st_nxt   = S_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TW'(osc_window(HOLD_OSC, int'(osc_cycles)) - 1);
      end
      S_SETUP: if (tmr_zero) begin
        st_nxt = S_VUP;  tmr_load = 1'b1; tmr_val = LEN_VUP;
      end
      S_VUP: if (tmr_zero) begin
        st_nxt = S_PLOW; tmr_load = 1'b1; tmr_val = LEN_LOW;
      end
      S_PLOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (pulse_last) begin st_nxt = S_VHOLD; tmr_val = LEN_VHLD; end
        else            begin st_nxt = S_PGAP;  tmr_val = LEN_GAP;  end
      end
      S_PGAP: if (tmr_zero) begin
        st_nxt = S_PLOW; tmr_load = 1'b1; tmr_val = LEN_LOW;
      end
      S_VHOLD: if (tmr_zero) begin
        st_nxt = S_AHOLD; tmr_load = 1'b1; tmr_val = r_hold;
      end
      S_AHOLD: if (tmr_zero) begin
        if (r_kind == K_CODE) begin
          st_nxt = S_VFY; tmr_load = 1'b1; tmr_val = r_hold;
        end else begin
          st_nxt = S_FIN;
        end
      end
      S_VFY:   if (tmr_zero) st_nxt = S_FIN;
      S_FIN:   st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      r_kind <= K_CODE;
      r_addr <= '0;
      r_data <= '0;
      r_hold <= '0;
      r_mism <= 1'b0;
    end else begin
      st <= st_nxt;
      if (accept) begin
        r_kind <= tgt_kind_e'(cmd_kind);
        r_addr <= cmd_addr;
        r_data <= cmd_data;
        r_hold <= TW'(osc_window(HOLD_OSC, int'(osc_cycles)) - 1);
        r_mism <= 1'b0;
      end else if (vfy_sample) begin
        r_mism <= (vfy_data != r_data);
      end
    end
  end

  logic in_prog_window;
  assign in_prog_window = (st == S_SETUP) || (st == S_VUP) || (st == S_PLOW) ||
                          (st == S_PGAP)  || (st == S_VHOLD) || (st == S_AHOLD);

  assign busy     = (st != S_IDLE);
  assign pin_addr = r_addr;
  assign pin_data = r_data;
  assign data_oe  = in_prog_window;
  assign mode_sel = in_prog_window ? mode_for(r_kind) : ((st == S_VFY) ? MODE_VFY : MODE_OFF);
  assign vpp_req  = (st == S_VUP) || (st == S_PLOW) || (st == S_PGAP) || (st == S_VHOLD);
  assign prog_n   = (st != S_PLOW);
  assign vfy_en_n = (st != S_VFY);
  assign done     = (st == S_FIN);
  assign err      = (st == S_FIN) && r_mism;

  // ---------------- assertions ----------------
  assert_prog_needs_vpp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> vpp_req && data_oe);

  assert_vfy_bus_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vfy_en_n |-> !vpp_req && !data_oe && mode_sel == MODE_VFY);

  assert_vfy_only_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vfy_en_n |-> r_kind == K_CODE);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> prog_n && !vpp_req && vfy_en_n && !data_oe && mode_sel == MODE_OFF);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pin_addr) && $stable(pin_data)));

  assert_vpp_rise_no_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_req) |-> prog_n);
endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int CLK_NS = 10;
  localparam int CPU    = 2;              // clocks per microsecond in the bench
  localparam int T_LOW  = 95 * CPU;
  localparam int T_GAP  = 10 * CPU;
  localparam int T_VSU  = 10 * CPU;
  localparam int T_VHD  = 10 * CPU;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_kind = 0;
  logic [14:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0, osc_cycles = 1;
  logic busy, data_oe, vpp_req, prog_n, vfy_en_n, done, err;
  logic [14:0] pin_addr;
  logic [7:0] pin_data, vfy_data;
  logic [2:0] mode_sel;

  always #(CLK_NS/2) clk = ~clk;

  otp_prog_seq #(.CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .osc_cycles(osc_cycles),
    .busy(busy), .pin_addr(pin_addr), .pin_data(pin_data), .data_oe(data_oe),
    .mode_sel(mode_sel), .vpp_req(vpp_req), .prog_n(prog_n), .vfy_en_n(vfy_en_n),
    .vfy_data(vfy_data), .done(done), .err(err)
  );

  // Target stand-in: 64-byte store written on PROG fall in code mode.
  logic [7:0] mem [64];
  logic [7:0] corrupt = 0;
  assign vfy_data = vfy_en_n ? 8'h00 : (mem[pin_addr[5:0]] ^ corrupt);

  // Monitor (negedge sampling)
  int cyc = 0, n_fall, t_ff, t_fall, t_lr, t_oe_r, t_oe_f, t_vr, t_vf;
  int lo_min, lo_max, gap_min, gap_max, vfy_cnt, done_cnt, err_cnt;
  logic [2:0] m_prog, m_vfy;
  logic p_prog = 1, p_oe = 0, p_vpp = 0;

  task automatic clr_mon();
    n_fall = 0; t_ff = 0; t_fall = 0; t_lr = 0; t_oe_r = 0; t_oe_f = 0; t_vr = 0; t_vf = 0;
    lo_min = 1 << 30; lo_max = 0; gap_min = 1 << 30; gap_max = 0;
    vfy_cnt = 0; done_cnt = 0; err_cnt = 0; m_prog = 0; m_vfy = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_prog && !prog_n) begin
        n_fall++;
        if (n_fall == 1) begin t_ff = cyc; m_prog = mode_sel; end
        else begin
          if (cyc - t_lr < gap_min) gap_min = cyc - t_lr;
          if (cyc - t_lr > gap_max) gap_max = cyc - t_lr;
        end
        t_fall = cyc;
        if (mode_sel == 3'b001 && vpp_req) mem[pin_addr[5:0]] = pin_data;
      end
      if (!p_prog && prog_n) begin
        t_lr = cyc;
        if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
        if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
      end
      if (!p_oe && data_oe) t_oe_r = cyc;
      if (p_oe && !data_oe) t_oe_f = cyc;
      if (!p_vpp && vpp_req) t_vr = cyc;
      if (p_vpp && !vpp_req) t_vf = cyc;
      if (!vfy_en_n) begin vfy_cnt++; m_vfy = mode_sel; end
      if (done) begin done_cnt++; if (err) err_cnt++; end
    end
    p_prog = prog_n; p_oe = data_oe; p_vpp = vpp_req;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] k, logic [14:0] a, logic [7:0] d, logic [7:0] o);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = k; cmd_addr = a; cmd_data = d; osc_cycles = o;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    if (n >= 20000) begin n_chk++; n_bad++; $display("FAIL watchdog: actual hung expected idle"); end
  endtask

  // kind, addr, data, osc, corrupt
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 15'h1234, 8'hA5, 8'd1, 8'h00, 1'b0},
    {2'b00, 15'h7FFF, 8'h3C, 8'd2, 8'h00, 1'b0},
    {2'b01, 15'h0005, 8'h5A, 8'd1, 8'h00, 1'b0},
    {2'b10, 15'h0002, 8'h00, 8'd1, 8'h00, 1'b0},
    {2'b00, 15'h0040, 8'h81, 8'd1, 8'h01, 1'b1},
    {2'b00, 15'h0001, 8'h00, 8'd0, 8'h00, 1'b0}
  };

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    clr_mon();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(busy), 0);       chk("R12 prog_n", int'(prog_n), 1);
    chk("R12 vpp", int'(vpp_req), 0);     chk("R12 vfy_en_n", int'(vfy_en_n), 1);
    chk("R12 mode", int'(mode_sel), 0);   chk("R12 addr", int'(pin_addr), 0);
    chk("R12 done/err", int'(done) + int'(err), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k;  logic [14:0] a;  logic [7:0] d, o, c;  logic e;
      int h, np;
      {k, a, d, o, c, e} = VEC[v];
      h  = 48 * ((o == 0) ? 1 : int'(o));      // R10 zero clamps to one
      np = (k == 2'b00) ? 5 : 25;
      corrupt = c;
      clr_mon();
      issue(k, a, d, o);
      chk("R1 busy after accept", int'(busy), 1);
      chk("R5 addr driven", int'(pin_addr), int'(a));
      chk("R5 data driven", int'(pin_data), int'(d));
      wait_idle();
      chk("R3 pulse count", n_fall, np);
      chk("R4 low width min", lo_min, T_LOW);
      chk("R4 low width max", lo_max, T_LOW);
      chk("R4 gap min", gap_min, T_GAP);
      chk("R4 gap max", gap_max, T_GAP);
      chk("R5 setup before first fall", t_ff - t_oe_r, h + T_VSU);
      chk("R5 hold after last rise", t_oe_f - t_lr, T_VHD + h);
      chk("R6 vpp lead", t_ff - t_vr, T_VSU);
      chk("R6 vpp lag", t_vf - t_lr, T_VHD);
      chk("R11 mode during pulses", int'(m_prog),
          (k == 2'b00) ? 1 : (k == 2'b01) ? 2 : 4);
      if (k == 2'b00) begin
        chk("R7 verify window", vfy_cnt, h);
        chk("R7 verify mode", int'(m_vfy), 3);
        chk("R7 err", err_cnt, int'(e));
      end else begin
        chk("R8 no verify", vfy_cnt, 0);
        chk("R8 no err", err_cnt, 0);
      end
      chk("R9 one done", done_cnt, 1);
      chk("R9 busy low", int'(busy), 0);
      chk("R11 idle mode", int'(mode_sel), 0);
    end
    corrupt = 0;

    // R1 reserved kind ignored
    clr_mon();
    issue(2'b11, 15'h0ABC, 8'h11, 8'd1);
    chk("R1 reserved busy", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R1 reserved still idle", int'(busy), 0);
    chk("R1 reserved no pulse", n_fall, 0);
    chk("R1 reserved vpp", int'(vpp_req), 0);

    // R2 command while busy ignored
    clr_mon();
    issue(2'b00, 15'h0111, 8'h22, 8'd1);
    repeat (100) @(negedge clk);
    issue(2'b01, 15'h2222, 8'h99, 8'd3);
    chk("R2 addr kept", int'(pin_addr), 15'h0111);
    chk("R2 data kept", int'(pin_data), 8'h22);
    wait_idle();
    chk("R2 pulse count kept", n_fall, 5);
    chk("R2 single done", done_cnt, 1);
    chk("R2 verify ok", err_cnt, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule